// File: doc/BRIEF.md
# Page Ownership Directory Manager

The directory manager keeps, for every page assigned to it, the identity of the owning node, whether the page is held read-write (W) or read-only (R), and a copyset bitmap with one bit per node that holds a valid copy. In mode W the copyset contains exactly the owner. In mode R the owner keeps a read-only copy and other nodes may also hold copies. Nodes report read faults and write faults on the request port. For each fault the manager issues an ordered series of commands on the command port: downgrade, copy, invalidate, and finally a grant. It waits for the addressed node's acknowledgement after every command except the grant.

Pages are spread across several managers by the low-order bits of the page number. A manager accepts only pages whose low `MGR_BITS` bits equal `MGR_ID`, and it indexes its local table with the remaining upper bits. Only one fault is handled at a time, and `req_ready` stays low until the grant has been taken.

The FSM states are IDLE, DECIDE, DOWN_SEND, DOWN_WAIT, COPY_SEND, COPY_WAIT, XFER, INV_SEND, INV_WAIT and GRANT. The transitions are:
- IDLE to DECIDE when it accepts an owned page.
- DECIDE to GRANT on a hit, to COPY_SEND, to DOWN_SEND, or to XFER.
- Each *_SEND state to its *_WAIT state on the `cmd_ready` handshake.
- DOWN_WAIT to XFER (write) or to COPY_SEND (read).
- COPY_WAIT to DOWN_SEND, XFER or GRANT.
- XFER to INV_SEND or GRANT.
- INV_WAIT to INV_SEND or GRANT.
- GRANT to IDLE.

Top module: `pgdir_manager`

## Requirements
- R1: After reset, `req_ready` is 1 and both `cmd_valid` and `ack_ready` are 0. Every page is owned by node 0 in mode W with copyset {0}.
- R2: Once a request is accepted, `req_ready` stays 0 until the grant handshake for that request completes. A command other than a grant is never presented while `req_ready` is 1.
- R3: `cmd_kind` uses the encoding 0=downgrade, 1=copy, 2=invalidate, 3=grant. A presented command keeps kind, destination and page stable until `cmd_ready`. `cmd_peer` always carries the requesting node.
- R4: A read from a node whose copyset bit is set, or a write from the owner of a page in W, produces only a grant to the requester and leaves the directory unchanged.
- R5: A read fault on a page in R from a node without a copy produces a copy command to the owner, then a grant. The requester is added to the copyset.
- R6: A read fault on a page in W produces a downgrade to the owner, then a copy to the owner, then a grant. The page ends in R, with the requester added to the copyset.
- R7: A write fault produces, in this order: a copy to the owner if the requester has no copy; a downgrade to the owner if the page is in W; an invalidate to every other copyset node in ascending node order, never to the requester; then a grant. Afterwards the requester owns the page in W with copyset {requester}.
- R8: Each downgrade, copy or invalidate waits for an acknowledgement from its destination node before the manager moves on. An acknowledgement from any other node is consumed and ignored. `ack_ready` and `cmd_valid` are never high together.
- R9: A request whose page has low `MGR_BITS` bits different from `MGR_ID` is accepted and dropped, with no command issued and no state changed. Every command carries a page number that belongs to this manager.
- R10: `cmd_write` on a grant equals the access type of the request being served (1 = write, 0 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fault request present |
| req_ready | output | 1 | Manager idle and accepting a request |
| req_node | input | NW | Faulting node |
| req_page | input | PW | Global page number |
| req_write | input | 1 | 1 = write fault, 0 = read fault |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken by the network |
| cmd_kind | output | 2 | 0 downgrade, 1 copy, 2 invalidate, 3 grant |
| cmd_dst | output | NW | Node the command is addressed to |
| cmd_page | output | PW | Page the command concerns |
| cmd_peer | output | NW | Requesting node (copy target) |
| cmd_write | output | 1 | Access granted is write (grant only) |
| ack_valid | input | 1 | Acknowledgement present |
| ack_ready | output | 1 | Manager waiting for an acknowledgement |
| ack_node | input | NW | Node sending the acknowledgement |

## Verification
The bench sweeps every node, every local page and both access types over several rounds, keeping its own directory model to predict the exact command series. It targets the following cases and the failure each would show:
- A write by a copy holder in R must skip the copy step. A design that always copied would emit an extra command.
- A write into a page in W by a non-owner must invalidate the old owner. Skipping it would leave two writers.
- Invalidates must come in ascending order and never go to the requester. Getting the scan wrong reorders or duplicates destinations.
- Stray acknowledgements from the wrong node are sent during waits. A design that advanced on them would present the next command too early.
- Requests for foreign pages must be dropped. Acting on them would emit commands or change state seen by later requests.

// File: rtl/pgdir_pkg.sv
package pgdir_pkg;

    typedef enum logic [1:0] {
        CMD_DOWN  = 2'd0,
        CMD_COPY  = 2'd1,
        CMD_INVAL = 2'd2,
        CMD_GRANT = 2'd3
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_DOWN_SEND,
        ST_DOWN_WAIT,
        ST_COPY_SEND,
        ST_COPY_WAIT,
        ST_XFER,
        ST_INV_SEND,
        ST_INV_WAIT,
        ST_GRANT
    } dir_state_e;

endpackage

// File: rtl/pgdir_store.sv
module pgdir_store #(
    parameter int NODES       = 4,
    parameter int LOCAL_PAGES = 4,
    parameter int NW          = 2,
    parameter int LW          = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    idx,
    output logic [NW-1:0]    rd_owner,
    output logic             rd_wmode,
    output logic [NODES-1:0] rd_cset,
    input  logic             owner_we,
    input  logic [NW-1:0]    owner_wd,
    input  logic             wmode_we,
    input  logic             wmode_wd,
    input  logic             cset_we,
    input  logic [NODES-1:0] cset_wd
);

    logic [NW-1:0]    owner_r [LOCAL_PAGES];
    logic             wmode_r [LOCAL_PAGES];
    logic [NODES-1:0] cset_r  [LOCAL_PAGES];

    // One register set per page; page p is written only when idx selects it.
    for (genvar p = 0; p < LOCAL_PAGES; p++) begin : g_page
        logic sel;
        assign sel = (idx == LW'(p));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                owner_r[p] <= '0;
                wmode_r[p] <= 1'b1;
                cset_r[p]  <= {{(NODES-1){1'b0}}, 1'b1};
            end else if (sel) begin
                if (owner_we) owner_r[p] <= owner_wd;
                if (wmode_we) wmode_r[p] <= wmode_wd;
                if (cset_we)  cset_r[p]  <= cset_wd;
            end
        end
    end

    assign rd_owner = owner_r[idx];
    assign rd_wmode = wmode_r[idx];
    assign rd_cset  = cset_r[idx];

endmodule

// File: rtl/pgdir_lowest.sv
module pgdir_lowest #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);

    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end

endmodule

// File: rtl/pgdir_manager.sv
module pgdir_manager
    import pgdir_pkg::*;
#(
    parameter int NODES       = 4,
    parameter int LOCAL_PAGES = 4,
    parameter int MGR_BITS    = 1,
    parameter int MGR_ID      = 1,
    localparam int NW = $clog2(NODES),
    localparam int LW = $clog2(LOCAL_PAGES),
    localparam int PW = LW + MGR_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [NW-1:0] req_node,
    input  logic [PW-1:0] req_page,
    input  logic          req_write,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [1:0]    cmd_kind,
    output logic [NW-1:0] cmd_dst,
    output logic [PW-1:0] cmd_page,
    output logic [NW-1:0] cmd_peer,
    output logic          cmd_write,
    input  logic          ack_valid,
    output logic          ack_ready,
    input  logic [NW-1:0] ack_node
);

    localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

    dir_state_e       state_q, state_d;
    logic [NW-1:0]    node_q;
    logic [PW-1:0]    page_q;
    logic             wr_q;
    logic [NODES-1:0] pend_q;

    logic [NW-1:0]    rd_owner;
    logic             rd_wmode;
    logic [NODES-1:0] rd_cset;
    logic             owner_we, wmode_we, wmode_wd, cset_we;
    logic [NODES-1:0] cset_wd;

    logic [NW-1:0]    inv_idx;
    logic             inv_any;
    logic [NODES-1:0] node_bit, xfer_pend, inv_rest;
    logic             has_copy, is_owner, ack_hit, own_page;
    logic [NW-1:0]    ack_expect;

    pgdir_store #(.NODES(NODES), .LOCAL_PAGES(LOCAL_PAGES), .NW(NW), .LW(LW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (page_q[PW-1:MGR_BITS]),
        .rd_owner (rd_owner),
        .rd_wmode (rd_wmode),
        .rd_cset  (rd_cset),
        .owner_we (owner_we),
        .owner_wd (node_q),
        .wmode_we (wmode_we),
        .wmode_wd (wmode_wd),
        .cset_we  (cset_we),
        .cset_wd  (cset_wd)
    );

    pgdir_lowest #(.N(NODES), .W(NW)) u_lowest (
        .vec (pend_q),
        .idx (inv_idx),
        .any (inv_any)
    );

    assign own_page   = (req_page[MGR_BITS-1:0] == MGR_BITS'(MGR_ID));
    assign node_bit   = ONE << node_q;
    assign has_copy   = rd_cset[node_q];
    assign is_owner   = (rd_owner == node_q);
    assign xfer_pend  = rd_cset & ~node_bit;
    assign inv_rest   = pend_q & ~(ONE << inv_idx);
    assign ack_expect = (state_q == ST_INV_WAIT) ? inv_idx : rd_owner;
    assign ack_hit    = ack_valid && ack_ready && (ack_node == ack_expect);

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            node_q  <= '0;
            page_q  <= '0;
            wr_q    <= 1'b0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                node_q <= req_node;
                page_q <= req_page;
                wr_q   <= req_write;
            end
            if (state_q == ST_XFER) pend_q <= xfer_pend;
            else if (state_q == ST_INV_WAIT && ack_hit) pend_q <= inv_rest;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid && own_page) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (!wr_q)
                    state_d = has_copy ? ST_GRANT : (rd_wmode ? ST_DOWN_SEND : ST_COPY_SEND);
                else if (rd_wmode && is_owner)
                    state_d = ST_GRANT;
                else if (!has_copy)
                    state_d = ST_COPY_SEND;
                else
                    state_d = rd_wmode ? ST_DOWN_SEND : ST_XFER;
            end
            ST_DOWN_SEND: if (cmd_ready) state_d = ST_DOWN_WAIT;
            ST_DOWN_WAIT: if (ack_hit) state_d = wr_q ? ST_XFER : ST_COPY_SEND;
            ST_COPY_SEND: if (cmd_ready) state_d = ST_COPY_WAIT;
            ST_COPY_WAIT: if (ack_hit)
                state_d = !wr_q ? ST_GRANT : (rd_wmode ? ST_DOWN_SEND : ST_XFER);
            ST_XFER:      state_d = (xfer_pend != '0) ? ST_INV_SEND : ST_GRANT;
            ST_INV_SEND:  if (cmd_ready) state_d = ST_INV_WAIT;
            ST_INV_WAIT:  if (ack_hit) state_d = (inv_rest != '0) ? ST_INV_SEND : ST_GRANT;
            ST_GRANT:     if (cmd_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs and directory updates
    always_comb begin
        req_ready = 1'b0;
        ack_ready = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind  = CMD_GRANT;
        cmd_dst   = rd_owner;
        cmd_page  = page_q;
        cmd_peer  = node_q;
        cmd_write = 1'b0;
        owner_we  = 1'b0;
        wmode_we  = 1'b0;
        wmode_wd  = 1'b0;
        cset_we   = 1'b0;
        cset_wd   = rd_cset;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_DECIDE:    ;
            ST_DOWN_SEND: begin cmd_valid = 1'b1; cmd_kind = CMD_DOWN; end
            ST_DOWN_WAIT: begin
                ack_ready = 1'b1;
                wmode_we  = ack_hit;
            end
            ST_COPY_SEND: begin cmd_valid = 1'b1; cmd_kind = CMD_COPY; end
            ST_COPY_WAIT: begin
                ack_ready = 1'b1;
                cset_we   = ack_hit && !wr_q;
                cset_wd   = rd_cset | node_bit;
            end
            ST_XFER:      owner_we = 1'b1;
            ST_INV_SEND:  begin
                cmd_valid = inv_any;
                cmd_kind  = CMD_INVAL;
                cmd_dst   = inv_idx;
            end
            ST_INV_WAIT:  ack_ready = 1'b1;
            ST_GRANT: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_GRANT;
                cmd_dst   = node_q;
                cmd_write = wr_q;
                wmode_we  = cmd_ready && wr_q;
                wmode_wd  = 1'b1;
                cset_we   = cmd_ready && wr_q;
                cset_wd   = node_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pgdir_manager_chk.sv
module pgdir_manager_chk #(
    parameter int NODES    = 4,
    parameter int MGR_BITS = 1,
    parameter int MGR_ID   = 1,
    parameter int NW       = 2,
    parameter int PW       = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_kind,
    input logic [NW-1:0] cmd_dst,
    input logic [PW-1:0] cmd_page,
    input logic [NW-1:0] cmd_peer,
    input logic          cmd_write,
    input logic          ack_ready
);

    logic          wr_seen;
    logic          inv_seen;
    logic [NW-1:0] last_inv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen  <= 1'b0;
            inv_seen <= 1'b0;
            last_inv <= '0;
        end else begin
            if (req_valid && req_ready) wr_seen <= req_write;
            if (cmd_valid && cmd_ready && cmd_kind == 2'd2) begin
                inv_seen <= 1'b1;
                last_inv <= cmd_dst;
            end else if (cmd_valid && cmd_ready && cmd_kind == 2'd3) begin
                inv_seen <= 1'b0;
            end
        end
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 2'd3) |-> !req_ready);

    // R3
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                       && $stable(cmd_dst) && $stable(cmd_page)));

    // R8
    ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ready |-> !cmd_valid);

    // R9
    page_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_page[MGR_BITS-1:0] == MGR_BITS'(MGR_ID)));

    // R10
    grant_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd3) |-> (cmd_write == wr_seen));

    // R7
    inv_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> (cmd_dst != cmd_peer));

    // R7
    inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_kind == 2'd2 && inv_seen) |-> (cmd_dst > last_inv));

endmodule

bind pgdir_manager pgdir_manager_chk #(
    .NODES(NODES), .MGR_BITS(MGR_BITS), .MGR_ID(MGR_ID), .NW(NW), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_dst(cmd_dst), .cmd_page(cmd_page),
    .cmd_peer(cmd_peer), .cmd_write(cmd_write), .ack_ready(ack_ready)
);

// File: tb/tb_pgdir_manager.sv
`timescale 1ns/1ps
module tb_pgdir_manager;

    localparam int NODES = 4;
    localparam int LPAGES = 4;
    localparam int MGRB = 1;
    localparam int MID = 1;
    localparam int NW = 2;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW-1:0] req_node = '0;
    logic [PW-1:0] req_page = '0;
    logic          req_write = 1'b0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [NW-1:0] cmd_dst;
    logic [PW-1:0] cmd_page;
    logic [NW-1:0] cmd_peer;
    logic          cmd_write;
    logic          ack_valid = 1'b0;
    logic          ack_ready;
    logic [NW-1:0] ack_node = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // model of the directory
    int         m_own [LPAGES];
    bit         m_wm  [LPAGES];
    bit [3:0]   m_cs  [LPAGES];

    int    ek [12];
    int    ed [12];
    int    en;
    string etag;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pgdir_manager #(.NODES(NODES), .LOCAL_PAGES(LPAGES), .MGR_BITS(MGRB), .MGR_ID(MID)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_page(req_page), .req_write(req_write),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_dst(cmd_dst), .cmd_page(cmd_page), .cmd_peer(cmd_peer),
        .cmd_write(cmd_write),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_node(ack_node)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic push(input int k, input int d);
        ek[en] = k;
        ed[en] = d;
        en++;
    endtask

    // Build the expected command series from the model and update it.
    task automatic predict(input int n, input int lp, input bit w);
        en = 0;
        if (!w) begin
            if (m_cs[lp][n]) begin
                etag = "R4";
            end else begin
                if (m_wm[lp]) begin
                    etag = "R6";
                    push(0, m_own[lp]);
                end else begin
                    etag = "R5";
                end
                push(1, m_own[lp]);
                m_wm[lp] = 1'b0;
                m_cs[lp][n] = 1'b1;
            end
            push(3, n);
        end else begin
            if (m_wm[lp] && m_own[lp] == n) begin
                etag = "R4";
            end else begin
                etag = "R7";
                if (!m_cs[lp][n]) push(1, m_own[lp]);
                if (m_wm[lp]) push(0, m_own[lp]);
                for (int i = 0; i < NODES; i++)
                    if (m_cs[lp][i] && i != n) push(2, i);
            end
            push(3, n);
            m_own[lp] = n;
            m_wm[lp] = 1'b1;
            m_cs[lp] = 4'(1 << n);
        end
    endtask

    task automatic run_req(input int n, input int lp, input bit w,
                           input bit stall, input bit stray);
        int t;
        int k_act, d_act;
        predict(n, lp, w);
        chk(req_ready == 1'b1, "R2", "idle ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_node  = NW'(n);
        req_page  = PW'(lp * 2 + MID);
        req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
        for (int c = 0; c < en; c++) begin
            t = 0;
            while (!cmd_valid && t < 60) begin
                @(negedge clk);
                t++;
            end
            if (!cmd_valid) begin
                chk(1'b0, etag, "command missing", c, en);
                return;
            end
            k_act = int'(cmd_kind);
            d_act = int'(cmd_dst);
            chk(k_act == ek[c], etag, "command kind", k_act, ek[c]);
            chk(d_act == ed[c], etag, "command destination", d_act, ed[c]);
            chk(cmd_page == PW'(lp * 2 + MID), "R9", "command page", cmd_page, lp * 2 + MID);
            chk(cmd_peer == NW'(n), "R3", "command peer", cmd_peer, n);
            if (ek[c] == 3)
                chk(cmd_write == w, "R10", "grant access", cmd_write, w);
            if (stall) begin
                @(negedge clk);
                chk(cmd_valid && int'(cmd_kind) == k_act && int'(cmd_dst) == d_act,
                    "R3", "command held under stall", int'(cmd_kind), k_act);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            if (ek[c] != 3) begin
                if (stray) begin
                    ack_valid = 1'b1;
                    ack_node  = NW'((ed[c] + 1) % NODES);
                    @(negedge clk);
                    ack_valid = 1'b0;
                    @(negedge clk);
                    chk(cmd_valid == 1'b0 && ack_ready == 1'b1, "R8",
                        "stray ack ignored", cmd_valid, 0);
                end
                chk(ack_ready == 1'b1, "R8", "waiting for ack", ack_ready, 1);
                ack_valid = 1'b1;
                ack_node  = NW'(ed[c]);
                @(negedge clk);
                ack_valid = 1'b0;
            end
        end
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R2", "idle after grant", req_ready, 1);
    endtask

    task automatic run_foreign(input int n, input int lp, input bit w);
        req_valid = 1'b1;
        req_node  = NW'(n);
        req_page  = PW'(lp * 2 + (1 - MID));
        req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(cmd_valid == 1'b0 && req_ready == 1'b1, "R9", "foreign page dropped",
                cmd_valid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < LPAGES; p++) begin
            m_own[p] = 0;
            m_wm[p]  = 1'b1;
            m_cs[p]  = 4'b0001;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
        chk(ack_ready == 1'b0, "R1", "reset ack_ready", ack_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R1", "idle after reset", req_ready, 1);

        // Node 0 owns every page in W after reset: its write is a pure grant (R4).
        run_req(0, 0, 1'b1, 1'b0, 1'b0);
        run_req(0, 1, 1'b0, 1'b0, 1'b0);

        for (int r = 0; r < 3; r++) begin
            for (int a = 0; a < NODES; a++) begin
                for (int lp = 0; lp < LPAGES; lp++) begin
                    for (int w = 0; w < 2; w++) begin
                        int n;
                        n = (r == 1) ? (NODES - 1 - a) : ((a + r * lp) % NODES);
                        run_req(n, lp, (w == 1) ^ (r == 2 && lp[0]),
                                ((n + lp + r) % 3) == 0, (r == 1) && ((n + lp) % 2 == 0));
                        if (((a + lp + w) % 5) == 0) run_foreign(a, lp, w[0]);
                    end
                end
            end
        end

        // Shared page then write by a non-owner copy holder (R7 without copy step).
        run_req(1, 3, 1'b0, 1'b0, 1'b0);
        run_req(2, 3, 1'b0, 1'b0, 1'b0);
        run_req(3, 3, 1'b0, 1'b0, 1'b0);
        run_req(2, 3, 1'b1, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule